// File: doc/BRIEF.md
# Receive Bit-Clock Recovery Loop with Delayed Transmit Strobe

This block rebuilds the bit timing of a 192 kbit/s line signal that has already been sliced into a logic-level data stream. It runs from a 7.68 MHz reference clock, so one bit spans 40 reference cycles. A phase counter steps through each bit window. Every data transition it sees pulls the counter by at most one cycle toward the transition, so line noise can only nudge the phase and never make it jump. A receive sample strobe fires at the middle of each window. A lock flag reports whether the transitions have been landing close to where the loop expects them.

The block also produces the transmit bit timing. It lags the recovered receive timing by two whole bit periods. A 2-bit select input can add an extra output delay on top of that lag, which helps meet the line's phase-deviation budget of -7% to +15% of a bit. A new select value is taken only at a bit boundary, so a transmit strobe is never lost or doubled.

Top module: `rx_bit_dpll`

## Requirements
- R1: While reset is high and in the cycle right after it falls, `phase_o` reads 0 and `rx_stb_o`, `tx_stb_o` and `lock_o` read 0. With no data transitions, the first `rx_stb_o` comes 20 cycles after the last reset cycle.
- R2: With no data transitions, the phase advances by one each cycle modulo 40. `rx_stb_o` is then a one-cycle pulse once every 40 cycles, when the phase is 20.
- R3: A data transition moves the phase by at most one cycle relative to free running. The phase advances by 0, 1 or 2 per cycle, so the spacing between `rx_stb_o` pulses is always 39, 40 or 41 cycles.
- R4: Suppose `rxd_i` changes just after rising edge n and the loop is aligned, which means it sees the transition at phase 0. The loop then makes no correction, and `rx_stb_o` is high in the cycle following rising edge n+21.
- R5: A bit is good when a transition falls within ±2 cycles of phase 0. `lock_o` rises one cycle after the bit boundary that completes 16 consecutive good bits. Bits with no transition neither count nor break the run.
- R6: A bit is a miss when its transitions all fall outside that ±2 window. `lock_o` falls only after 8 consecutive misses and stays high through fewer.
- R7: Transmit timing lags receive timing by two bits. No `tx_stb_o` appears before the third bit boundary after reset. From that boundary on, exactly one `tx_stb_o` occurs per bit.
- R8: The delay select `dly_sel_i` places `tx_stb_o` after the bit boundary (the first cycle of a bit window) by 0 cycles for code 0, 2 cycles for code 1, 4 cycles for code 2 and 8 cycles for code 3.
- R9: `dly_sel_i` is sampled only in the first cycle of each bit window. A change made later in a bit affects only the following bit, and no strobe is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7.68 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Sliced receive data, synchronous to clk |
| dly_sel_i | input | 2 | Extra transmit output delay code |
| rx_stb_o | output | 1 | Receive sample strobe, mid bit |
| tx_stb_o | output | 1 | Transmit bit strobe |
| lock_o | output | 1 | Loop locked to the data transitions |
| phase_o | output | 6 | Current phase within the bit window (0 to 39) |

## Verification
Two events can fall in the same bit: a new delay code arriving while a transmit strobe is still pending under the old code, and the bit boundary where the code is latched. The bench runs with code 3 and then changes the code three cycles after a boundary, before the delayed strobe is due. It checks that the strobe still arrives at the old offset and that the new offset applies only from the next boundary. It also makes the reverse change, from code 0 to a long delay just after an early strobe has fired, and uses the scoreboard to report any second strobe in that bit. The scoreboard predicts each strobe from the cycle in which the bench toggled the data, and it fails on a strobe that is missing, late or extra.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int unsigned NOM_BIT_CYC  = 40;
    localparam int unsigned NOM_SAMPLE   = 20;
    localparam int unsigned NOM_NEAR_WIN = 2;
    localparam int unsigned NOM_DLY_UNIT = 2;

    typedef enum logic [1:0] {
        EDGE_NONE,
        EDGE_ON,
        EDGE_LATE,
        EDGE_EARLY
    } edge_kind_e;

    typedef struct packed {
        edge_kind_e kind;
        logic       near;
    } edge_evt_t;

    function automatic int unsigned dly_of(input logic [1:0] code, input int unsigned unit);
        if (code == 2'd0)
            return 0;
        return unit << (int'(code) - 1);
    endfunction

endpackage

// File: rtl/dpll_phase_track.sv
module dpll_phase_track
    import dpll_pkg::*;
#(
    parameter int unsigned BIT_CYC  = NOM_BIT_CYC,
    parameter int unsigned PH_W     = 6,
    parameter int unsigned NEAR_WIN = NOM_NEAR_WIN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rxd_i,
    output logic [PH_W-1:0] ph_o,
    output logic            new_bit_o,
    output edge_evt_t       evt_o
);

    localparam logic [PH_W-1:0] HALF   = PH_W'(BIT_CYC / 2);
    localparam logic [PH_W-1:0] NEAR   = PH_W'(NEAR_WIN);
    localparam logic [PH_W-1:0] FAR_LO = PH_W'(BIT_CYC - NEAR_WIN);

    function automatic logic [PH_W-1:0] wrap_add(input logic [PH_W-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= int'(BIT_CYC))
            s = s - int'(BIT_CYC);
        return PH_W'(s);
    endfunction

    logic            d1_q, d2_q;
    logic [PH_W-1:0] ph_q, ph_n;
    logic            nb_q;
    logic            edge_seen;
    edge_evt_t       evt;

    assign edge_seen = d1_q ^ d2_q;

    always_comb begin
        evt.near = edge_seen && ((ph_q <= NEAR) || (ph_q >= FAR_LO));
        if (!edge_seen)
            evt.kind = EDGE_NONE;
        else if (ph_q == '0)
            evt.kind = EDGE_ON;
        else if (ph_q < HALF)
            evt.kind = EDGE_LATE;
        else
            evt.kind = EDGE_EARLY;
    end

    always_comb begin
        case (evt.kind)
            EDGE_LATE:  ph_n = ph_q;
            EDGE_EARLY: ph_n = wrap_add(ph_q, 2);
            default:    ph_n = wrap_add(ph_q, 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d1_q <= 1'b0;
            d2_q <= 1'b0;
            ph_q <= '0;
            nb_q <= 1'b0;
        end else begin
            d1_q <= rxd_i;
            d2_q <= d1_q;
            ph_q <= ph_n;
            nb_q <= (ph_n < ph_q);
        end
    end

    assign ph_o      = ph_q;
    assign new_bit_o = nb_q;
    assign evt_o     = evt;

    // R3
    ph_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ph_q == wrap_add($past(ph_q), 0)) ||
                  (ph_q == wrap_add($past(ph_q), 1)) ||
                  (ph_q == wrap_add($past(ph_q), 2))));

    // R2
    ph_range_chk: assert property (@(posedge clk) disable iff (rst)
        ph_q < PH_W'(BIT_CYC));

endmodule

// File: rtl/dpll_lock_mon.sv
module dpll_lock_mon
    import dpll_pkg::*;
#(
    parameter int unsigned GOOD_N = 16,
    parameter int unsigned MISS_N = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      new_bit_i,
    input  edge_evt_t evt_i,
    output logic      lock_o
);

    localparam int unsigned GW = $clog2(GOOD_N + 1);
    localparam int unsigned MW = $clog2(MISS_N + 1);

    logic          hit_q, far_q, lock_q;
    logic [GW-1:0] good_q;
    logic [MW-1:0] miss_q;
    logic          far_now;

    assign far_now = (evt_i.kind != EDGE_NONE) && !evt_i.near;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            far_q  <= 1'b0;
            lock_q <= 1'b0;
            good_q <= '0;
            miss_q <= '0;
        end else begin
            hit_q <= new_bit_i ? evt_i.near : (hit_q | evt_i.near);
            far_q <= new_bit_i ? far_now    : (far_q | far_now);
            if (new_bit_i) begin
                if (hit_q) begin
                    miss_q <= '0;
                    if (good_q != GW'(GOOD_N))
                        good_q <= good_q + 1'b1;
                    if (good_q >= GW'(GOOD_N - 1))
                        lock_q <= 1'b1;
                end else if (far_q) begin
                    good_q <= '0;
                    if (miss_q != MW'(MISS_N))
                        miss_q <= miss_q + 1'b1;
                    if (miss_q >= MW'(MISS_N - 1))
                        lock_q <= 1'b0;
                end
            end
        end
    end

    assign lock_o = lock_q;

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> ($past(new_bit_i) && $past(good_q) >= GW'(GOOD_N - 1)));

    // R6
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> ($past(new_bit_i) && $past(miss_q) >= MW'(MISS_N - 1)));

endmodule

// File: rtl/dpll_tx_timing.sv
module dpll_tx_timing
    import dpll_pkg::*;
#(
    parameter int unsigned BIT_CYC  = NOM_BIT_CYC,
    parameter int unsigned DLY_UNIT = NOM_DLY_UNIT,
    parameter int unsigned LAG_BITS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       new_bit_i,
    input  logic [1:0] sel_i,
    output logic       tx_stb_o
);

    localparam int unsigned CW = $clog2(BIT_CYC + 2);
    localparam int unsigned LW = $clog2(LAG_BITS + 1);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q, offs;
    logic [1:0]    code_q, code_eff;
    logic [LW-1:0] seen_q;
    logic          on_q, armed;

    assign code_eff = new_bit_i ? sel_i : code_q;
    assign offs     = new_bit_i ? '0 : cnt_q;
    assign armed    = on_q || (new_bit_i && (seen_q == LW'(LAG_BITS)));
    assign tx_stb_o = armed && (offs == CW'(dly_of(code_eff, DLY_UNIT)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_MAX;
            code_q <= 2'd0;
            seen_q <= '0;
            on_q   <= 1'b0;
        end else begin
            code_q <= code_eff;
            if (new_bit_i)
                cnt_q <= CW'(1);
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
            if (new_bit_i && seen_q != LW'(LAG_BITS))
                seen_q <= seen_q + 1'b1;
            if (armed)
                on_q <= 1'b1;
        end
    end

    // R9
    tx_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_stb_o |=> !tx_stb_o);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !new_bit_i |=> $stable(code_q));

    // R7
    tx_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_stb_o && !on_q) |-> new_bit_i);

endmodule

// File: rtl/rx_bit_dpll.sv
module rx_bit_dpll
    import dpll_pkg::*;
#(
    parameter int unsigned BIT_CYC    = NOM_BIT_CYC,
    parameter int unsigned SAMPLE_POS = NOM_SAMPLE,
    parameter int unsigned NEAR_WIN   = NOM_NEAR_WIN,
    parameter int unsigned DLY_UNIT   = NOM_DLY_UNIT,
    parameter int unsigned LAG_BITS   = 2,
    parameter int unsigned GOOD_N     = 16,
    parameter int unsigned MISS_N     = 8,
    localparam int unsigned PH_W      = $clog2(BIT_CYC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rxd_i,
    input  logic [1:0]      dly_sel_i,
    output logic            rx_stb_o,
    output logic            tx_stb_o,
    output logic            lock_o,
    output logic [PH_W-1:0] phase_o
);

    logic            new_bit;
    logic [PH_W-1:0] ph;
    edge_evt_t       evt;

    dpll_phase_track #(
        .BIT_CYC (BIT_CYC),
        .PH_W    (PH_W),
        .NEAR_WIN(NEAR_WIN)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .rxd_i    (rxd_i),
        .ph_o     (ph),
        .new_bit_o(new_bit),
        .evt_o    (evt)
    );

    dpll_lock_mon #(
        .GOOD_N(GOOD_N),
        .MISS_N(MISS_N)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .new_bit_i(new_bit),
        .evt_i    (evt),
        .lock_o   (lock_o)
    );

    dpll_tx_timing #(
        .BIT_CYC (BIT_CYC),
        .DLY_UNIT(DLY_UNIT),
        .LAG_BITS(LAG_BITS)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .new_bit_i(new_bit),
        .sel_i    (dly_sel_i),
        .tx_stb_o (tx_stb_o)
    );

    assign rx_stb_o = (ph == PH_W'(SAMPLE_POS));
    assign phase_o  = ph;

    // R2
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_stb_o |=> !rx_stb_o);

    // R7
    tx_vs_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_stb_o && rx_stb_o) |-> 1'b0);

endmodule

// File: tb/rx_bit_dpll_bench.sv
module rx_bit_dpll_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       rx_stb, tx_stb, lock;
    logic [5:0] phase;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int rbase = 0;
    int last_tog = -1000;
    int nbnd = 0;
    int last_stb = -1;
    bit sb_en = 1'b1;
    bit align_chk = 1'b0;
    bit done = 1'b0;
    int exp_q[$];

    rx_bit_dpll u_rx_bit_dpll (
        .clk      (clk),
        .rst      (rst),
        .rxd_i    (rxd),
        .dly_sel_i(sel),
        .rx_stb_o (rx_stb),
        .tx_stb_o (tx_stb),
        .lock_o   (lock),
        .phase_o  (phase)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int code_delay(input logic [1:0] c);
        case (c)
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Driver: toggle the line, push the predicted transmit strobe
    task automatic bit_out(input int a, input logic [1:0] nsel, input int b);
        repeat (a) @(negedge clk);
        sel = nsel;
        repeat (b) @(negedge clk);
        rxd = ~rxd;
        last_tog = cyc;
        nbnd++;
        if (sb_en && nbnd >= 3)
            exp_q.push_back(cyc + 1 + code_delay(sel));
    endtask

    // Monitor: scoreboard for tx, timing for rx
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sb_en) begin
                if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                    chk(1'b0, "R8 missing tx", cyc, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                if (tx_stb) begin
                    if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                        chk(1'b1, "R9", cyc, cyc);
                        void'(exp_q.pop_front());
                    end else begin
                        chk(1'b0, "R7 unexpected tx", cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
                    end
                end
            end
            if (rx_stb) begin
                if (last_stb >= 0)
                    chk((cyc - last_stb) >= 39 && (cyc - last_stb) <= 41, "R3 spacing",
                        cyc - last_stb, 40);
                last_stb = cyc;
            end
            if (align_chk && cyc == last_tog + 21)
                chk(rx_stb, "R4 sample strobe", int'(rx_stb), 1);
        end
    end

    // Probe of fixed points after reset
    initial begin
        @(negedge clk);
        wait (!rst);
        forever begin
            @(negedge clk);
            if (cyc == rbase + 19) chk(!rx_stb, "R1 early strobe", int'(rx_stb), 0);
            if (cyc == rbase + 20) chk(rx_stb, "R1 first strobe", int'(rx_stb), 1);
            if (cyc == rbase + 30) chk(phase == 6'd30, "R2 free-run phase", int'(phase), 30);
            if (cyc == rbase + 680) chk(!lock, "R5 lock too soon", int'(lock), 0);
            if (cyc == rbase + 681) chk(lock, "R5 lock after 16 good", int'(lock), 1);
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", cyc, 200000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(phase == 0 && !rx_stb && !tx_stb && !lock, "R1 in reset",
            {phase, rx_stb, tx_stb, lock}, 0);
        rst = 1'b0;
        rbase = cyc;
        @(negedge clk);
        chk(phase == 6'd1 && !tx_stb && !lock, "R1 after reset",
            {phase, tx_stb, lock}, 6'd1 << 2);

        // aligned stream, code 0: lag, alignment, lock
        align_chk = 1'b1;
        bit_out(0, 2'd0, 38);
        for (int i = 0; i < 19; i++) bit_out(20, 2'd0, 20);

        // each delay code in turn
        for (int c = 1; c < 4; c++)
            for (int i = 0; i < 4; i++) bit_out(20, 2'(c), 20);
        for (int i = 0; i < 3; i++) bit_out(20, 2'd0, 20);

        // code change while a delayed strobe is pending
        bit_out(20, 2'd3, 20);
        bit_out(20, 2'd3, 20);
        bit_out(3, 2'd0, 37);
        bit_out(20, 2'd0, 20);
        bit_out(3, 2'd3, 37);
        bit_out(20, 2'd2, 20);
        bit_out(20, 2'd2, 20);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        chk(lock, "R5 still locked", int'(lock), 1);

        // phase step of half a bit: misses
        sb_en = 1'b0;
        align_chk = 1'b0;
        bit_out(0, 2'd0, 40);
        for (int i = 0; i < 4; i++) bit_out(20, 2'd0, 20);
        chk(lock, "R6 holds through few misses", int'(lock), 1);
        for (int i = 0; i < 9; i++) bit_out(20, 2'd0, 20);
        chk(!lock, "R6 drops after 8 misses", int'(lock), 0);
        for (int i = 0; i < 40; i++) bit_out(20, 2'd0, 20);
        chk(lock, "R5 relock", int'(lock), 1);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule